// File: doc/BRIEF.md
# Converter Start-Pulse and Byte-Read Bus Interface

This block joins a 10-bit successive-approximation converter to an 8-bit processor bus. The processor starts a conversion by writing to a decoded start address. The block then raises the converter's blank/convert line and holds it high until the converter answers by raising its ready flag. Dropping the line on that answer starts the conversion. Because the converter itself ends the pulse, the pulse is always long enough, and no timer is needed.

When the converter lowers its ready flag at the end of a conversion, the block latches the 10-bit result. It returns the result through two byte reads with left justification. The high-byte read returns the eight most significant bits. The low-byte read returns the two least significant bits in its top two positions. A third read address returns the converter's ready flag, so software can poll for completion.

All selects and strobes are active low and synchronous to `clk`. Read data is combinational from the selects and the read strobe.

Top module: `conv_bus_glue`

## Requirements
- R1: After a synchronous reset, `blank_conv` is low, `bus_oe` is low, and the held result is zero (a high-byte read returns 0x00).
- R2: A start command is `wr_n` low while `start_sel_n` is low. It is detected once, at the first clock edge where both are sampled low. `blank_conv` is high from that edge onward.
- R3: Once raised, `blank_conv` stays high until `conv_rdy` is sampled high. It is low from that edge onward, and the conversion is then in progress.
- R4: While a conversion is in progress, the first edge that samples `conv_rdy` low latches `conv_data` as the result. The interface then returns to standby.
- R5: A start command that arrives while `blank_conv` is high or a conversion is in progress is ignored. No pulse follows it, and it is not remembered.
- R6: `wr_n` low while `start_sel_n` is high does not raise `blank_conv`.
- R7: `bus_oe` is high only while `rd_n` is low and at least one of `hi_sel_n`, `lo_sel_n`, `stat_sel_n` is low. Whenever `bus_oe` is low, `bus_dout` is 0x00.
- R8: A high-byte read (`hi_sel_n` low) returns result bits 9..2 on `bus_dout` 7..0.
- R9: A low-byte read (`lo_sel_n` low) returns result bits 1..0 on `bus_dout` 7..6, with bits 5..0 zero.
- R10: A status read (`stat_sel_n` low) returns the live `conv_rdy` on `bus_dout` bit 7, with bits 6..0 zero.
- R11: The held result does not change through later start commands or pulses. It changes only when a conversion completes.
- R12: When several read selects are low together, the high byte wins over the low byte, and the low byte wins over status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_sel_n | input | 1 | Decoded start address, active low |
| hi_sel_n | input | 1 | Decoded high-byte read address, active low |
| lo_sel_n | input | 1 | Decoded low-byte read address, active low |
| stat_sel_n | input | 1 | Decoded status read address, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| conv_rdy | input | 1 | Converter ready flag (high while busy) |
| conv_data | input | 10 | Converter result bits |
| blank_conv | output | 1 | Blank/convert line to the converter |
| bus_dout | output | 8 | Byte driven toward the processor bus |
| bus_oe | output | 1 | Output enable for the bus buffer |

## Verification
The bench drives every input just after a falling clock edge. A start command sampled at the next rising edge shows up on `blank_conv` right after that edge, with no further delay. The bench therefore checks `blank_conv` at the falling edge that follows. A `conv_rdy` change likewise moves `blank_conv` or the held result one rising edge later, and the bench checks at the next falling edge. Reads have no latency: the bench asserts select and `rd_n` mid-cycle, waits one time unit, and compares `bus_dout` and `bus_oe` before any clock edge intervenes.

// File: rtl/cbg_pkg.sv
// Shared types for the converter bus interface.
package cbg_pkg;
    // Sequencer phases: standby, start pulse out, conversion running.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_CONV  = 2'd2
    } cbg_state_e;
endpackage

// File: rtl/cbg_start_detect.sv
// Turns the start-address write into a single-cycle request.
// Assumes select and strobe are synchronous to clk.
// A held write produces only one request.
module cbg_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic start_sel_n,
    input  logic wr_n,
    output logic start_req
);
    logic wr_hit;
    logic wr_hit_q;

    // Combined write to the start address.
    assign wr_hit = ~start_sel_n & ~wr_n;

    // Remember the previous sample so that only the leading edge counts.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_hit_q <= 1'b0;
        else        wr_hit_q <= wr_hit;
    end

    // Request on the first cycle of the write.
    assign start_req = wr_hit & ~wr_hit_q;
endmodule

// File: rtl/cbg_seq.sv
// Start-pulse sequencer. It raises blank/convert on a request, ends the
// pulse when the converter raises ready, and signals capture when ready
// drops again. Requests outside standby are dropped.
module cbg_seq
    import cbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       conv_rdy,
    output cbg_state_e state,
    output logic       blank_conv,
    output logic       capture
);
    cbg_state_e state_nx;

    // Next-state choice for the three phases.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_req) state_nx = ST_PULSE;
            ST_PULSE: if (conv_rdy)  state_nx = ST_CONV;
            ST_CONV:  if (!conv_rdy) state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Pulse line follows the pulse phase; capture marks end of conversion.
    assign blank_conv = (state == ST_PULSE);
    assign capture    = (state == ST_CONV) & ~conv_rdy;
endmodule

// File: rtl/cbg_result.sv
// Holds the last completed conversion result until the next completes.
module cbg_result #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] conv_data,
    output logic [DATA_W-1:0] result
);
    // Load only on the completion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       result <= '0;
        else if (capture) result <= conv_data;
    end
endmodule

// File: rtl/cbg_read_mux.sv
// Read-side byte selection with left justification and bus gating.
// Assumes DATA_W > BUS_W and DATA_W <= 2*BUS_W.
module cbg_read_mux #(
    parameter int DATA_W = 10,
    parameter int BUS_W  = 8
) (
    input  logic              hi_sel_n,
    input  logic              lo_sel_n,
    input  logic              stat_sel_n,
    input  logic              rd_n,
    input  logic              conv_rdy,
    input  logic [DATA_W-1:0] result,
    output logic [BUS_W-1:0]  bus_dout,
    output logic              bus_oe
);
    localparam int LO_BITS = DATA_W - BUS_W;

    logic [BUS_W-1:0] hi_byte;
    logic [BUS_W-1:0] lo_byte;
    logic [BUS_W-1:0] st_byte;

    // Top bits of the result form the high byte.
    assign hi_byte = result[DATA_W-1 -: BUS_W];

    // Remaining bits sit at the top of the low byte, zero filled below.
    generate
        if (LO_BITS == BUS_W) begin : g_lo_full
            assign lo_byte = result[LO_BITS-1:0];
        end else begin : g_lo_pad
            assign lo_byte = {result[LO_BITS-1:0], {(BUS_W-LO_BITS){1'b0}}};
        end
    endgenerate

    // Status byte carries ready in the top bit.
    assign st_byte = {conv_rdy, {(BUS_W-1){1'b0}}};

    // Drive only during a selected read; priority high, low, status.
    always_comb begin
        bus_oe   = 1'b0;
        bus_dout = '0;
        if (!rd_n) begin
            if (!hi_sel_n) begin
                bus_oe   = 1'b1;
                bus_dout = hi_byte;
            end else if (!lo_sel_n) begin
                bus_oe   = 1'b1;
                bus_dout = lo_byte;
            end else if (!stat_sel_n) begin
                bus_oe   = 1'b1;
                bus_dout = st_byte;
            end
        end
    end
endmodule

// File: rtl/conv_bus_glue.sv
// Top level: joins a successive-approximation converter to a byte bus.
// Assumes all selects and strobes are synchronous to clk, and assumes the
// converter holds ready high for the whole conversion.
module conv_bus_glue
    import cbg_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_sel_n,
    input  logic              hi_sel_n,
    input  logic              lo_sel_n,
    input  logic              stat_sel_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              conv_rdy,
    input  logic [DATA_W-1:0] conv_data,
    output logic              blank_conv,
    output logic [BUS_W-1:0]  bus_dout,
    output logic              bus_oe
);
    logic              start_req;
    logic              capture;
    cbg_state_e        seq_state;
    logic [DATA_W-1:0] result;

    // Write-side request detection.
    cbg_start_detect u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_sel_n (start_sel_n),
        .wr_n        (wr_n),
        .start_req   (start_req)
    );

    // Pulse and conversion sequencing.
    cbg_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .conv_rdy   (conv_rdy),
        .state      (seq_state),
        .blank_conv (blank_conv),
        .capture    (capture)
    );

    // Result holding register.
    cbg_result #(.DATA_W(DATA_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .conv_data (conv_data),
        .result    (result)
    );

    // Byte selection toward the bus.
    cbg_read_mux #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_mux (
        .hi_sel_n   (hi_sel_n),
        .lo_sel_n   (lo_sel_n),
        .stat_sel_n (stat_sel_n),
        .rd_n       (rd_n),
        .conv_rdy   (conv_rdy),
        .result     (result),
        .bus_dout   (bus_dout),
        .bus_oe     (bus_oe)
    );
endmodule

// File: rtl/conv_bus_glue_chk.sv
// Property checker attached to every instance of conv_bus_glue.
module conv_bus_glue_chk
    import cbg_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int BUS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_sel_n,
    input logic              hi_sel_n,
    input logic              lo_sel_n,
    input logic              stat_sel_n,
    input logic              rd_n,
    input logic              conv_rdy,
    input logic              blank_conv,
    input logic [BUS_W-1:0]  bus_dout,
    input logic              bus_oe,
    input cbg_state_e        seq_state,
    input logic [DATA_W-1:0] result
);
    // R1: the first cycle out of reset is quiet.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !blank_conv);

    // R3: the pulse holds until ready is seen.
    a_r3_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_conv && !conv_rdy) |=> blank_conv);

    // R3: ready ends the pulse.
    a_r3_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_conv && conv_rdy) |=> !blank_conv);

    // R5: no new pulse directly out of a running conversion.
    a_r5_busy_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_CONV) |=> !blank_conv);

    // R6: standby without the start select stays in standby.
    a_r6_unselected_write: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_IDLE && start_sel_n) |=> !blank_conv);

    // R7: the bus is driven only during a read.
    a_r7_oe_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !rd_n);

    // R7: an undriven bus carries zero.
    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_dout == '0));

    // R10: a status-only read has nothing below the top bit.
    a_r10_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !stat_sel_n && hi_sel_n && lo_sel_n) |-> (bus_dout[BUS_W-2:0] == '0));

    // R11: the result moves only on leaving a conversion.
    a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != ST_CONV) |=> $stable(result));
endmodule

bind conv_bus_glue conv_bus_glue_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_sel_n (start_sel_n),
    .hi_sel_n    (hi_sel_n),
    .lo_sel_n    (lo_sel_n),
    .stat_sel_n  (stat_sel_n),
    .rd_n        (rd_n),
    .conv_rdy    (conv_rdy),
    .blank_conv  (blank_conv),
    .bus_dout    (bus_dout),
    .bus_oe      (bus_oe),
    .seq_state   (seq_state),
    .result      (result)
);

// File: tb/sim_conv_bus_glue.sv
// Directed bench: one task per scenario, each checks its own results.
module sim_conv_bus_glue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_sel_n = 1'b1;
    logic       hi_sel_n = 1'b1;
    logic       lo_sel_n = 1'b1;
    logic       stat_sel_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       conv_rdy = 1'b0;
    logic [9:0] conv_data = '0;
    logic       blank_conv;
    logic [7:0] bus_dout;
    logic       bus_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    conv_bus_glue u0 (
        .clk(clk), .rst_n(rst_n), .start_sel_n(start_sel_n),
        .hi_sel_n(hi_sel_n), .lo_sel_n(lo_sel_n), .stat_sel_n(stat_sel_n),
        .wr_n(wr_n), .rd_n(rd_n), .conv_rdy(conv_rdy), .conv_data(conv_data),
        .blank_conv(blank_conv), .bus_dout(bus_dout), .bus_oe(bus_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_blank(input logic exp, input string req);
        check(blank_conv === exp, req, int'(blank_conv), int'(exp));
    endtask

    // Mid-cycle read; output is combinational.
    task automatic rd(input logic h, input logic l, input logic s,
                      input logic [7:0] exp, input logic exp_oe, input string req);
        hi_sel_n = h; lo_sel_n = l; stat_sel_n = s; rd_n = 1'b0;
        #1;
        check(bus_dout === exp, req, int'(bus_dout), int'(exp));
        check(bus_oe === exp_oe, {req, " oe"}, int'(bus_oe), int'(exp_oe));
        hi_sel_n = 1'b1; lo_sel_n = 1'b1; stat_sel_n = 1'b1; rd_n = 1'b1;
    endtask

    // One-cycle write to the start address.
    task automatic start_cmd();
        @(negedge clk); start_sel_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); start_sel_n = 1'b1; wr_n = 1'b1;
    endtask

    // Converter answers the pulse, runs, then finishes with data.
    task automatic run_conv(input logic [9:0] d);
        @(negedge clk); conv_rdy = 1'b1;
        @(negedge clk); chk_blank(1'b0, "R3 pulse ends on ready");
        @(negedge clk); conv_data = d; conv_rdy = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk_blank(1'b0, "R1 blank after reset");
        check(bus_oe === 1'b0, "R1 oe after reset", int'(bus_oe), 0);
        rd(1'b0, 1'b1, 1'b1, 8'h00, 1'b1, "R1 result zero");
    endtask

    task automatic t_basic(input logic [9:0] d);
        start_cmd();
        chk_blank(1'b1, "R2 pulse raised");
        run_conv(d);
        chk_blank(1'b0, "R4 standby after end");
        rd(1'b0, 1'b1, 1'b1, d[9:2], 1'b1, "R8 high byte");
        rd(1'b1, 1'b0, 1'b1, {d[1:0], 6'b0}, 1'b1, "R9 low byte");
    endtask

    task automatic t_pulse_hold();
        start_cmd();
        for (int i = 0; i < 4; i++) begin
            chk_blank(1'b1, "R3 pulse held");
            @(negedge clk);
        end
        run_conv(10'h155);
        rd(1'b0, 1'b1, 1'b1, 8'h55, 1'b1, "R4 captured");
    endtask

    task automatic t_busy_ignore();
        start_cmd();
        // Start again while pulsing: ignored, ready still ends the pulse.
        @(negedge clk); start_sel_n = 1'b0; wr_n = 1'b0; conv_rdy = 1'b1;
        @(negedge clk); start_sel_n = 1'b1; wr_n = 1'b1;
        chk_blank(1'b0, "R5 start during pulse ignored");
        // Start while converting.
        start_cmd();
        chk_blank(1'b0, "R5 start during conversion ignored");
        conv_data = 10'h0F0; conv_rdy = 1'b0;
        @(negedge clk);
        chk_blank(1'b0, "R5 not remembered");
        @(negedge clk);
        chk_blank(1'b0, "R5 still standby");
        rd(1'b0, 1'b1, 1'b1, 8'h3C, 1'b1, "R4 result after busy test");
    endtask

    task automatic t_unselected();
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); chk_blank(1'b0, "R6 write without select");
        // Select arrives while write held: counts as a start.
        start_sel_n = 1'b0;
        @(negedge clk); chk_blank(1'b1, "R2 select joins held write");
        wr_n = 1'b1; start_sel_n = 1'b1;
        run_conv(10'h3FF);
        rd(1'b0, 1'b1, 1'b1, 8'hFF, 1'b1, "R8 all ones high");
        rd(1'b1, 1'b0, 1'b1, 8'hC0, 1'b1, "R9 all ones low");
    endtask

    task automatic t_gate();
        rd(1'b1, 1'b1, 1'b1, 8'h00, 1'b0, "R7 read no select");
        hi_sel_n = 1'b0; #1;
        check(bus_oe === 1'b0 && bus_dout === 8'h00, "R7 select without read",
              int'(bus_dout), 0);
        hi_sel_n = 1'b1;
    endtask

    task automatic t_status();
        @(negedge clk); conv_rdy = 1'b1;
        rd(1'b1, 1'b1, 1'b0, 8'h80, 1'b1, "R10 ready high");
        @(negedge clk); conv_rdy = 1'b0;
        rd(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, "R10 ready low");
    endtask

    task automatic t_hold();
        // Result 0x3FF from earlier must survive a new pulse.
        start_cmd();
        rd(1'b0, 1'b1, 1'b1, 8'hFF, 1'b1, "R11 held during pulse");
        @(negedge clk); conv_rdy = 1'b1;
        @(negedge clk); conv_data = 10'h001;
        rd(1'b1, 1'b0, 1'b1, 8'hC0, 1'b1, "R11 held during conversion");
        conv_rdy = 1'b0;
        @(negedge clk);
        rd(1'b1, 1'b0, 1'b1, 8'h40, 1'b1, "R11 updated on completion");
        rd(1'b0, 1'b1, 1'b1, 8'h00, 1'b1, "R8 zero high");
    endtask

    task automatic t_priority();
        // Result now 0x001: high 0x00, low 0x40.
        conv_rdy = 1'b1;
        rd(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R12 high over low and status");
        rd(1'b1, 1'b0, 1'b0, 8'h40, 1'b1, "R12 low over status");
        conv_rdy = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic(10'h2D5);
        t_pulse_hold();
        t_busy_ignore();
        t_unselected();
        t_gate();
        t_status();
        t_hold();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule